// File: doc/BRIEF.md
# Partition Write-Protection Guard

This block decides whether an address in a 512 KiB nonvolatile array may be written. It keeps eight partition registers. Each register holds a 6-bit endpoint and a 2-bit behaviour code. In enhanced mode the registers split the array into ordered regions. In legacy mode a 2-bit block-protect field guards fixed upper regions of the array. The protection answer is combinational from the current configuration, the write-protect pin and the queried address.

Configuration arrives as decoded commands: an opcode, a 24-bit address and one data byte, all qualified by a valid strobe. Serial shifting is done elsewhere. The general write-enable latch also lives outside this block. The guard reads that latch on an input and requests that it be cleared through a one-cycle pulse. The guard owns the partition write-enable latch, the boundary-protect bit and the freeze bit. Every configuration command needs both latches set and the freeze bit clear. The boundary and freeze commands also need a fixed address key.

Top module: `npg_guard`

## Requirements
- R1: After reset all eight partition registers read 0x00, the partition latch (`prel`), boundary bit (`pabp`) and freeze bit (`fmpc`) are 0, and in enhanced mode no address is protected.
- R2: Opcode 0x07 sets `prel` and opcode 0x0A clears it, one cycle after the command.
- R3: Opcode 0x31 returns the register selected by address bits 18:16 on `rd_data`, with `rd_valid` high, one cycle after the command.
- R4: Opcode 0x32 writes the data byte to the register selected by address bits 18:16, but only when `wel_i`, `prel` are 1 and `fmpc` is 0. When the write is accepted, `prel` clears and `wel_clr` pulses for one cycle. Otherwise nothing changes.
- R5: While `pabp` is 1, an accepted 0x32 updates only bits 7:6 (the behaviour code) and keeps the endpoint bits 5:0.
- R6: A register whose behaviour code is 11 ignores 0x32 writes. The accepted command still clears both latches.
- R7: Opcode 0x34 with address bits 15:0 = 0xCC55 and gate open sets `pabp` on data 0xFF, clears it on 0x00, and leaves it unchanged on any other byte. In every case it clears both latches. With any other key the command does nothing.
- R8: Opcode 0x37 with address bits 15:0 = 0xAA40 and gate open clears both latches. It sets `fmpc` only when the data byte is 0xD2. Once set, `fmpc` stays set and blocks 0x32, 0x34 and 0x37.
- R9: In enhanced mode (`enh_mode_i`=1) register i has endpoint {bits 5:0, 13 ones}. Registers are scanned from index 0. A register whose endpoint is not above the previous accepted endpoint is skipped. An address belongs to the first accepted register whose endpoint is at or above it. Codes 01 and 11 protect, code 00 does not.
- R10: Behaviour code 10 protects its region only while `wp_i` is 1.
- R11: In enhanced mode an address above every accepted endpoint is unprotected.
- R12: In legacy mode (`enh_mode_i`=0) `bp_i` 00 protects nothing, 01 protects 0x60000–0x7FFFF, 10 protects 0x40000–0x7FFFF and 11 protects everything. `bp_i` has no effect in enhanced mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Decoded command present this cycle |
| cmd_op | input | 8 | Command opcode |
| cmd_addr | input | 24 | Command address field |
| cmd_data | input | 8 | First data byte of the command |
| wel_i | input | 1 | General write-enable latch state |
| enh_mode_i | input | 1 | 1 = partition mode, 0 = legacy block-protect mode |
| bp_i | input | 2 | Legacy block-protect field |
| wp_i | input | 1 | Write-protect pin, 1 = asserted |
| chk_addr | input | 19 | Array address being queried |
| chk_protected | output | 1 | 1 = queried address may not be written |
| rd_valid | output | 1 | Read-partition data valid |
| rd_data | output | 8 | Read-partition data |
| wel_clr | output | 1 | One-cycle request to clear the general write-enable latch |
| prel | output | 1 | Partition write-enable latch |
| pabp | output | 1 | Boundary-protect bit |
| fmpc | output | 1 | Freeze bit |

## Verification
The region lookup uses a register layout with a skipped out-of-order endpoint, a pin-dependent region, a locked region and an uncovered tail. Probes placed at each region edge show whether the endpoint encoding and the first-match scan are right. Commands are sent once with a latch missing, once with a wrong key and once with a wrong confirmation byte. Each is sent again with everything correct, which separates the gate from the key from the data check. The legacy sweep probes both sides of each fixed boundary and flips `bp_i` in enhanced mode to show that it is ignored there.

// File: rtl/npg_pkg.sv
package npg_pkg;
  parameter int ADDR_W = 19;
  parameter int EP_W   = 6;
  parameter int NPART  = 8;
  localparam int LOW_W = ADDR_W - EP_W;
  localparam int IDX_W = $clog2(NPART);

  typedef enum logic [1:0] {
    PB_OPEN = 2'b00,
    PB_SWP  = 2'b01,
    PB_HWP  = 2'b10,
    PB_LOCK = 2'b11
  } pb_e;

  localparam logic [7:0] OP_PREL_SET = 8'h07;
  localparam logic [7:0] OP_PREL_CLR = 8'h0A;
  localparam logic [7:0] OP_RD_PART  = 8'h31;
  localparam logic [7:0] OP_WR_PART  = 8'h32;
  localparam logic [7:0] OP_BOUND    = 8'h34;
  localparam logic [7:0] OP_FREEZE   = 8'h37;

  localparam logic [15:0] KEY_BOUND  = 16'hCC55;
  localparam logic [15:0] KEY_FREEZE = 16'hAA40;
  localparam logic [7:0]  BOUND_ON   = 8'hFF;
  localparam logic [7:0]  BOUND_OFF  = 8'h00;
  localparam logic [7:0]  FREEZE_OK  = 8'hD2;

  // Endpoint: upper bits from the register, low bits all ones.
  function automatic logic [ADDR_W-1:0] ep_to_addr(input logic [EP_W-1:0] ep);
    return {ep, {LOW_W{1'b1}}};
  endfunction

  function automatic logic code_blocks(input logic [1:0] pb, input logic wp);
    return (pb == PB_SWP) || (pb == PB_LOCK) || ((pb == PB_HWP) && wp);
  endfunction

  function automatic logic legacy_blocks(input logic [1:0] bp,
                                         input logic [ADDR_W-1:0] a);
    case (bp)
      2'b01:   return a[ADDR_W-1] & a[ADDR_W-2];
      2'b10:   return a[ADDR_W-1];
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/npg_cmd_decode.sv
module npg_cmd_decode
  import npg_pkg::*;
(
  input  logic        cmd_valid,
  input  logic [7:0]  cmd_op,
  input  logic [15:0] key_addr,
  input  logic [7:0]  cmd_data,
  input  logic        wel_i,
  input  logic        prel,
  input  logic        fmpc,
  output logic        do_prel_set,
  output logic        do_prel_clr,
  output logic        do_read,
  output logic        do_wr_part,
  output logic        do_latch_clr,
  output logic        bound_set,
  output logic        bound_clr,
  output logic        freeze_set
);
  logic gate_ok;
  logic bound_go;
  logic freeze_go;

  assign gate_ok     = wel_i & prel & ~fmpc;
  assign do_prel_set = cmd_valid && (cmd_op == OP_PREL_SET);
  assign do_prel_clr = cmd_valid && (cmd_op == OP_PREL_CLR);
  assign do_read     = cmd_valid && (cmd_op == OP_RD_PART);
  assign do_wr_part  = cmd_valid && (cmd_op == OP_WR_PART) && gate_ok;
  assign bound_go    = cmd_valid && (cmd_op == OP_BOUND) && gate_ok &&
                       (key_addr == KEY_BOUND);
  assign freeze_go   = cmd_valid && (cmd_op == OP_FREEZE) && gate_ok &&
                       (key_addr == KEY_FREEZE);

  assign do_latch_clr = do_wr_part | bound_go | freeze_go;
  assign bound_set    = bound_go && (cmd_data == BOUND_ON);
  assign bound_clr    = bound_go && (cmd_data == BOUND_OFF);
  assign freeze_set   = freeze_go && (cmd_data == FREEZE_OK);
endmodule

// File: rtl/npg_part_regs.sv
module npg_part_regs
  import npg_pkg::*;
#(
  parameter int NP = NPART,
  localparam int IW = $clog2(NP)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               do_prel_set,
  input  logic               do_prel_clr,
  input  logic               do_read,
  input  logic               do_wr_part,
  input  logic               do_latch_clr,
  input  logic               bound_set,
  input  logic               bound_clr,
  input  logic               freeze_set,
  input  logic [IW-1:0]      sel,
  input  logic [7:0]         wdata,
  output logic [NP-1:0][7:0] regs,
  output logic               prel,
  output logic               pabp,
  output logic               fmpc,
  output logic               rd_valid,
  output logic [7:0]         rd_data,
  output logic               wel_clr
);
  logic sel_locked;
  assign sel_locked = (regs[sel][7:6] == PB_LOCK);

  for (genvar i = 0; i < NP; i++) begin : g_reg
    logic hit;
    assign hit = do_wr_part && (sel == IW'(i)) && !sel_locked;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    regs[i] <= 8'h00;
      else if (hit) begin
        if (pabp) regs[i][7:6] <= wdata[7:6];
        else      regs[i]      <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prel     <= 1'b0;
      pabp     <= 1'b0;
      fmpc     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
      wel_clr  <= 1'b0;
    end else begin
      if (do_latch_clr)     prel <= 1'b0;
      else if (do_prel_set) prel <= 1'b1;
      else if (do_prel_clr) prel <= 1'b0;
      if (bound_set)        pabp <= 1'b1;
      else if (bound_clr)   pabp <= 1'b0;
      if (freeze_set)       fmpc <= 1'b1;
      rd_valid <= do_read;
      if (do_read) rd_data <= regs[sel];
      wel_clr  <= do_latch_clr;
    end
  end
endmodule

// File: rtl/npg_prot_lookup.sv
module npg_prot_lookup
  import npg_pkg::*;
#(
  parameter int NP = NPART
) (
  input  logic [NP-1:0][7:0]  regs,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wp,
  input  logic                enh,
  input  logic [1:0]          bp,
  output logic                blocked,
  output logic                part_found
);
  logic [ADDR_W-1:0] prev_end;
  logic              have_prev;
  logic              part_block;
  logic [ADDR_W-1:0] this_end;

  always_comb begin
    prev_end   = '0;
    have_prev  = 1'b0;
    part_found = 1'b0;
    part_block = 1'b0;
    this_end   = '0;
    for (int i = 0; i < NP; i++) begin
      this_end = ep_to_addr(regs[i][EP_W-1:0]);
      if (!have_prev || (this_end > prev_end)) begin
        if (!part_found && (addr <= this_end)) begin
          part_found = 1'b1;
          part_block = code_blocks(regs[i][7:6], wp);
        end
        prev_end  = this_end;
        have_prev = 1'b1;
      end
    end
  end

  assign blocked = enh ? part_block : legacy_blocks(bp, addr);
endmodule

// File: rtl/npg_guard.sv
module npg_guard
  import npg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [7:0]  cmd_op,
  input  logic [23:0] cmd_addr,
  input  logic [7:0]  cmd_data,
  input  logic        wel_i,
  input  logic        enh_mode_i,
  input  logic [1:0]  bp_i,
  input  logic        wp_i,
  input  logic [18:0] chk_addr,
  output logic        chk_protected,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  output logic        wel_clr,
  output logic        prel,
  output logic        pabp,
  output logic        fmpc
);
  logic do_prel_set, do_prel_clr, do_read, do_wr_part, do_latch_clr;
  logic bound_set, bound_clr, freeze_set;
  logic part_found;
  logic [NPART-1:0][7:0] regs;
  logic [IDX_W-1:0] sel;

  assign sel = cmd_addr[16 +: IDX_W];

  npg_cmd_decode u_dec (
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .key_addr     (cmd_addr[15:0]),
    .cmd_data     (cmd_data),
    .wel_i        (wel_i),
    .prel         (prel),
    .fmpc         (fmpc),
    .do_prel_set  (do_prel_set),
    .do_prel_clr  (do_prel_clr),
    .do_read      (do_read),
    .do_wr_part   (do_wr_part),
    .do_latch_clr (do_latch_clr),
    .bound_set    (bound_set),
    .bound_clr    (bound_clr),
    .freeze_set   (freeze_set)
  );

  npg_part_regs #(.NP(NPART)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .do_prel_set  (do_prel_set),
    .do_prel_clr  (do_prel_clr),
    .do_read      (do_read),
    .do_wr_part   (do_wr_part),
    .do_latch_clr (do_latch_clr),
    .bound_set    (bound_set),
    .bound_clr    (bound_clr),
    .freeze_set   (freeze_set),
    .sel          (sel),
    .wdata        (cmd_data),
    .regs         (regs),
    .prel         (prel),
    .pabp         (pabp),
    .fmpc         (fmpc),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .wel_clr      (wel_clr)
  );

  npg_prot_lookup #(.NP(NPART)) u_look (
    .regs       (regs),
    .addr       (chk_addr),
    .wp         (wp_i),
    .enh        (enh_mode_i),
    .bp         (bp_i),
    .blocked    (chk_protected),
    .part_found (part_found)
  );
endmodule

// File: rtl/npg_guard_chk.sv
module npg_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [7:0]  cmd_op,
  input logic        wel_i,
  input logic        enh_mode_i,
  input logic [1:0]  bp_i,
  input logic        chk_protected,
  input logic        rd_valid,
  input logic        wel_clr,
  input logic        prel,
  input logic        pabp,
  input logic        fmpc
);
  a_r2_prel_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 8'h07) |=> prel);
  a_r3_rd_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_valid && cmd_op == 8'h31));
  a_r4_clr_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> $past(cmd_valid && wel_i && prel && !fmpc));
  a_r7_pabp_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pabp) |-> $past(cmd_valid && cmd_op == 8'h34));
  a_r8_freeze_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fmpc |=> fmpc);
  a_r8_frozen_no_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (fmpc && cmd_valid && cmd_op == 8'h32) |=> !wel_clr);
  a_r12_legacy_all: assert property (@(posedge clk) disable iff (!rst_n)
    (!enh_mode_i && bp_i == 2'b11) |-> chk_protected);
endmodule

bind npg_guard npg_guard_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_op        (cmd_op),
  .wel_i         (wel_i),
  .enh_mode_i    (enh_mode_i),
  .bp_i          (bp_i),
  .chk_protected (chk_protected),
  .rd_valid      (rd_valid),
  .wel_clr       (wel_clr),
  .prel          (prel),
  .pabp          (pabp),
  .fmpc          (fmpc)
);

// File: tb/tb_npg_guard.sv
`timescale 1ns/1ps
module tb_npg_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_op = 8'h00;
  logic [23:0] cmd_addr = 24'h0;
  logic [7:0]  cmd_data = 8'h00;
  logic        wel_i = 1'b0;
  logic        enh_mode_i = 1'b1;
  logic [1:0]  bp_i = 2'b00;
  logic        wp_i = 1'b0;
  logic [18:0] chk_addr = 19'h0;
  logic        chk_protected, rd_valid, wel_clr, prel, pabp, fmpc;
  logic [7:0]  rd_data;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;
  logic seen_clr;

  always #2.5 clk = ~clk;

  npg_guard dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] op, input logic [23:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    #1;
    seen_clr = wel_clr;
  endtask

  task automatic rd_part(input int idx, input logic [7:0] exp, input string tag);
    send(8'h31, {5'd0, 3'(idx), 16'h0}, 8'h00);
    chk({tag, " rd_valid"}, rd_valid, 1);
    chk(tag, rd_data, exp);
  endtask

  task automatic probe(input logic [18:0] a, input logic exp, input string tag);
    chk_addr = a;
    #1;
    chk(tag, chk_protected, exp);
  endtask

  task automatic wr_part(input int idx, input logic [7:0] d);
    wel_i = 1'b1;
    send(8'h07, 24'h0, 8'h00);
    send(8'h32, {5'd0, 3'(idx), 16'h0}, d);
  endtask

  task automatic t_reset;
    chk("R1 prel", prel, 0);
    chk("R1 pabp", pabp, 0);
    chk("R1 fmpc", fmpc, 0);
    rd_part(3, 8'h00, "R1 reg3");
    probe(19'h7FFFF, 0, "R1 top open");
    probe(19'h00000, 0, "R1 bottom open");
  endtask

  task automatic t_prel;
    send(8'h07, 24'h0, 8'h00);
    chk("R2 set", prel, 1);
    send(8'h0A, 24'h0, 8'h00);
    chk("R2 clr", prel, 0);
  endtask

  task automatic t_write_gate;
    wel_i = 1'b0;
    send(8'h07, 24'h0, 8'h00);
    send(8'h32, 24'h000000, 8'h45);
    chk("R4 no wel no clr", seen_clr, 0);
    chk("R4 prel kept", prel, 1);
    rd_part(0, 8'h00, "R4 no wel unchanged");
    send(8'h0A, 24'h0, 8'h00);
    wel_i = 1'b1;
    send(8'h32, 24'h000000, 8'h45);
    chk("R4 no prel no clr", seen_clr, 0);
    rd_part(0, 8'h00, "R4 no prel unchanged");
    wr_part(0, 8'h45);
    chk("R4 wel_clr pulse", seen_clr, 1);
    chk("R4 prel cleared", prel, 0);
    rd_part(0, 8'h45, "R4 reg0 written");
  endtask

  task automatic t_layout;
    wr_part(1, 8'h03);  // open, end 0x07FFF: not above 0x0BFFF -> skipped
    wr_part(2, 8'h8F);  // pin-protected, end 0x1FFFF
    wr_part(3, 8'h1F);  // open, end 0x3FFFF
    wr_part(4, 8'hE7);  // locked, end 0x4FFFF
    wr_part(5, 8'h50);  // sw, end 0x21FFF: skipped
    rd_part(4, 8'hE7, "R3 reg4 readback");
    rd_part(5, 8'h50, "R3 reg5 readback");
    wp_i = 1'b0;
    probe(19'h00000, 1, "R9 reg0 low");
    probe(19'h0BFFF, 1, "R9 reg0 end");
    probe(19'h0C000, 0, "R10 reg2 pin low");
    wp_i = 1'b1;
    probe(19'h0C000, 1, "R10 reg2 pin high");
    probe(19'h1FFFF, 1, "R10 reg2 end");
    wp_i = 1'b0;
    probe(19'h21000, 0, "R9 skipped reg5 has no claim");
    probe(19'h3FFFF, 0, "R9 reg3 open");
    probe(19'h40000, 1, "R9 reg4 locked code");
    probe(19'h4FFFF, 1, "R9 reg4 end");
    probe(19'h50000, 0, "R11 beyond last");
    probe(19'h7FFFF, 0, "R11 top");
  endtask

  task automatic t_locked;
    wr_part(4, 8'h00);
    chk("R6 latch still cleared", seen_clr, 1);
    chk("R6 prel cleared", prel, 0);
    rd_part(4, 8'hE7, "R6 locked kept");
  endtask

  task automatic t_bound;
    wel_i = 1'b1;
    send(8'h07, 24'h0, 8'h00);
    send(8'h34, 24'h00CC54, 8'hFF);
    chk("R7 bad key pabp", pabp, 0);
    chk("R7 bad key prel kept", prel, 1);
    send(8'h34, 24'h00CC55, 8'hFF);
    chk("R7 set", pabp, 1);
    chk("R7 latches cleared", prel, 0);
    wr_part(3, 8'h40);
    rd_part(3, 8'h5F, "R5 code only");
    probe(19'h20000, 1, "R5 new code active");
    send(8'h07, 24'h0, 8'h00);
    send(8'h34, 24'h00CC55, 8'h12);
    chk("R7 odd byte keeps", pabp, 1);
    chk("R7 odd byte clears latch", seen_clr, 1);
    send(8'h07, 24'h0, 8'h00);
    send(8'h34, 24'h00CC55, 8'h00);
    chk("R7 clear", pabp, 0);
  endtask

  task automatic t_freeze;
    wel_i = 1'b1;
    send(8'h07, 24'h0, 8'h00);
    send(8'h37, 24'h00AA41, 8'hD2);
    chk("R8 bad key", fmpc, 0);
    send(8'h37, 24'h00AA40, 8'h11);
    chk("R8 bad confirm", fmpc, 0);
    chk("R8 bad confirm clears", seen_clr, 1);
    send(8'h07, 24'h0, 8'h00);
    send(8'h37, 24'h00AA40, 8'hD2);
    chk("R8 frozen", fmpc, 1);
    send(8'h07, 24'h0, 8'h00);
    send(8'h32, 24'h000000, 8'h00);
    chk("R8 write blocked no clr", seen_clr, 0);
    chk("R8 prel kept", prel, 1);
    rd_part(0, 8'h45, "R8 reg0 unchanged");
    send(8'h34, 24'h00CC55, 8'hFF);
    chk("R8 bound blocked", pabp, 0);
    chk("R8 sticky", fmpc, 1);
  endtask

  task automatic t_legacy;
    enh_mode_i = 1'b0;
    bp_i = 2'b00; probe(19'h7FFFF, 0, "R12 bp00");
    bp_i = 2'b01; probe(19'h5FFFF, 0, "R12 bp01 below");
    probe(19'h60000, 1, "R12 bp01 edge");
    bp_i = 2'b10; probe(19'h3FFFF, 0, "R12 bp10 below");
    probe(19'h40000, 1, "R12 bp10 edge");
    bp_i = 2'b11; probe(19'h00000, 1, "R12 bp11 bottom");
    enh_mode_i = 1'b1;
    probe(19'h50000, 0, "R12 bp ignored in enhanced");
    bp_i = 2'b00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_prel();
    t_write_gate();
    t_layout();
    t_locked();
    t_bound();
    t_freeze();
    t_legacy();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule